// File: doc/BRIEF.md
# Frame-transfer EMCCD clock sequencer

This block produces the digital clock and strobe pattern that a frame-transfer, electron-multiplying CCD needs, one logic level per pin per cycle, for level shifters and an analog front-end to act on downstream. A single start pulse launches a frame. First every image row is moved into the light-shielded storage array, with the image and storage parallel clocks stepping together. Then the storage array is read out one row at a time. Each row goes into the serial register with a storage-only line shift, and is then clocked out pixel by pixel through the gain register. The serial clocks, the gain-register clock and three per-pixel strobes (reset gate, reference clamp, signal sample) all run together during this readout.

While rows are read out, the image array holds its integration level and collects the next scene. The count of pixel periods per row covers the real columns, the gain-register stages that must be flushed, and a run of overscan pixels. A qualifier marks only the sample strobes that carry real image columns. A start request that arrives during a frame is held and launches the next frame as soon as the current one ends. Row count, column count, gain-stage count, overscan count and the length of each parallel phase step are run-time inputs. The pixel period and strobe positions are parameters.

Top module: `ccd_seq_top`

## Requirements
- R1: While `rst_n` is low, and after it is released until a start, `img_clk` and `sto_clk` are 3'b001, and `ser_clk`, `mult_clk`, all three strobes, `pix_valid` and `frame_done` are 0.
- R2: A start sampled in idle begins the frame shift in the next cycle. For `cfg_rows` row moves, `img_clk` and `sto_clk` carry the same one-hot value. Each row move holds bit 0, then bit 1, then bit 2, each for `cfg_step` cycles. The serial outputs stay 0 throughout.
- R3: Each row readout begins with a line shift lasting 3*`cfg_step` cycles. In it, `sto_clk` steps through bit 0, bit 1 and bit 2, while `img_clk` holds 3'b001 and the serial outputs stay 0.
- R4: After each line shift come `cfg_cols`+`cfg_mult`+`cfg_ovr` pixel periods of `PIX_DIV` cycles each (8 by default). Within a period, at cycle offset p, `ser_clk` is one-hot: bit 0 for p < PIX_DIV/3, bit 1 for p < 2*(PIX_DIV/3), and bit 2 otherwise.
- R5: In every pixel period, `rst_gate`, `clamp_strb` and `samp_strb` are each high for exactly one cycle. They fall at offsets `RST_AT`, `CLAMP_AT` and `SAMP_AT` (defaults 0, 2, 5).
- R6: `mult_clk` is high during offsets PIX_DIV/2 to PIX_DIV-1 of every pixel period, and low at all other times.
- R7: `pix_valid` is high only together with `samp_strb`, and only in pixel periods with index k (counting from 0 within a row) where `cfg_mult` <= k < `cfg_mult`+`cfg_cols`.
- R8: When the last pixel period of the last row ends, `frame_done` is high for exactly one cycle. In that same cycle the block returns to idle levels, unless a start is pending.
- R9: A start pulse seen while a frame is running is held, and the next frame shift then begins in the cycle where `frame_done` is high. Several pulses during one frame produce only one further frame.
- R10: The image clocks keep the integration level 3'b001 while any serial clock is active. The storage clocks do the same.
- R11: A `cfg_step` of 0 behaves as a step length of 1 cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Frame request, sampled on the rising clock edge |
| cfg_rows | input | ROW_W | Rows per array (at least 1) |
| cfg_cols | input | COL_W | Real image columns per row |
| cfg_mult | input | MULT_W | Gain-register stages to flush per row |
| cfg_ovr | input | OVR_W | Overscan pixels per row |
| cfg_step | input | STEP_W | Cycles per parallel phase step |
| img_clk | output | 3 | Image-array parallel phases |
| sto_clk | output | 3 | Storage-array parallel phases |
| ser_clk | output | 3 | Serial-register phases |
| mult_clk | output | 1 | Gain-register clock |
| rst_gate | output | 1 | Output-node reset strobe |
| clamp_strb | output | 1 | Reference-level clamp strobe |
| samp_strb | output | 1 | Signal-level sample strobe |
| pix_valid | output | 1 | Marks samples of real image columns |
| frame_done | output | 1 | One-cycle end-of-frame pulse |

## Verification
All outputs decode combinationally from registered state. A start sampled at rising edge E0 therefore shows as frame-shift phase 0 in the cycle right after E0. From then on, each output level follows from the number of edges counted since E0 and the frame geometry. The frame pulse rises on the edge that ends the last pixel period: one frame length, rows*(6*step + cols_total*PIX_DIV) cycles, after E0. The bench keeps an edge index n from E0 and compares every output at the falling edge of cycle n against levels worked out from R2 to R8. It drives start at the falling edge, so each request lands on a known edge.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FRAME = 2'd1,
    ST_LINE  = 2'd2,
    ST_PIXEL = 2'd3
  } seq_state_e;

  // Parallel clocks rest with phase 1 high to hold the charge wells
  localparam logic [2:0] PAR_REST = 3'b001;

  function automatic logic [2:0] phase_onehot(input logic [1:0] idx);
    return 3'b001 << idx;
  endfunction

endpackage

// File: rtl/ccd_par_stepper.sv
module ccd_par_stepper #(
  parameter int STEP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [STEP_W-1:0] cfg_step,
  output logic              row_end,
  output logic [2:0]        phase
);
  import ccd_seq_pkg::*;

  logic [STEP_W-1:0] step_cnt, step_cnt_nx, step_lim;
  logic [1:0]        ph, ph_nx;
  logic              last_step, cnt_en;

  assign step_lim  = (cfg_step == '0) ? '0 : cfg_step - STEP_W'(1);
  assign last_step = (step_cnt == step_lim);
  assign cnt_en    = run | (ph != 2'd0) | (step_cnt != '0);

  always_comb begin
    step_cnt_nx = step_cnt;
    ph_nx       = ph;
    if (!run) begin
      step_cnt_nx = '0;
      ph_nx       = 2'd0;
    end else if (last_step) begin
      step_cnt_nx = '0;
      ph_nx       = (ph == 2'd2) ? 2'd0 : ph + 2'd1;
    end else begin
      step_cnt_nx = step_cnt + STEP_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_cnt <= '0;
      ph       <= 2'd0;
    end else if (cnt_en) begin
      step_cnt <= step_cnt_nx;
      ph       <= ph_nx;
    end
  end

  assign row_end = run & last_step & (ph == 2'd2);
  assign phase   = run ? phase_onehot(ph) : PAR_REST;

endmodule

// File: rtl/ccd_pix_timer.sv
module ccd_pix_timer #(
  parameter int PIX_DIV  = 8,
  parameter int RST_AT   = 0,
  parameter int CLAMP_AT = 2,
  parameter int SAMP_AT  = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  output logic       pix_end,
  output logic [2:0] ser_ph,
  output logic       mult_clk,
  output logic       rst_gate,
  output logic       clamp_strb,
  output logic       samp_strb
);
  localparam int PW     = $clog2(PIX_DIV);
  localparam int PH_LEN = PIX_DIV / 3;

  logic [PW-1:0] pos, pos_nx;
  logic [31:0]   pos_w;
  logic          cnt_en;

  assign cnt_en = run | (pos != '0);

  always_comb begin
    if (!run || pos == PW'(PIX_DIV - 1)) pos_nx = '0;
    else                                 pos_nx = pos + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pos <= '0;
    else if (cnt_en) pos <= pos_nx;
  end

  assign pos_w = 32'(pos);

  for (genvar k = 0; k < 3; k++) begin : g_ser
    localparam int LO = k * PH_LEN;
    localparam int HI = (k == 2) ? PIX_DIV : (k + 1) * PH_LEN;
    assign ser_ph[k] = run & (pos_w >= 32'(LO)) & (pos_w < 32'(HI));
  end

  assign pix_end    = run & (pos == PW'(PIX_DIV - 1));
  assign mult_clk   = run & (pos_w >= 32'(PIX_DIV / 2));
  assign rst_gate   = run & (pos == PW'(RST_AT));
  assign clamp_strb = run & (pos == PW'(CLAMP_AT));
  assign samp_strb  = run & (pos == PW'(SAMP_AT));

endmodule

// File: rtl/ccd_seq_top.sv
module ccd_seq_top #(
  parameter int ROW_W    = 10,
  parameter int COL_W    = 10,
  parameter int MULT_W   = 10,
  parameter int OVR_W    = 6,
  parameter int STEP_W   = 8,
  parameter int PIX_DIV  = 8,
  parameter int RST_AT   = 0,
  parameter int CLAMP_AT = 2,
  parameter int SAMP_AT  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ROW_W-1:0]  cfg_rows,
  input  logic [COL_W-1:0]  cfg_cols,
  input  logic [MULT_W-1:0] cfg_mult,
  input  logic [OVR_W-1:0]  cfg_ovr,
  input  logic [STEP_W-1:0] cfg_step,
  output logic [2:0]        img_clk,
  output logic [2:0]        sto_clk,
  output logic [2:0]        ser_clk,
  output logic              mult_clk,
  output logic              rst_gate,
  output logic              clamp_strb,
  output logic              samp_strb,
  output logic              pix_valid,
  output logic              frame_done
);
  import ccd_seq_pkg::*;

  localparam int WMAX1 = (COL_W > MULT_W) ? COL_W : MULT_W;
  localparam int TOT_W = ((WMAX1 > OVR_W) ? WMAX1 : OVR_W) + 2;

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i_n = rst_pipe[1];

  seq_state_e       state, state_nx;
  logic [ROW_W-1:0] row_cnt, row_nx, rows_last;
  logic [TOT_W-1:0] col_cnt, col_nx, col_total, col_last, win_lo, win_hi;
  logic             pend, pend_nx, done_nx;
  logic             par_run, par_row_end, pix_run, pix_end;
  logic [2:0]       par_phase;
  logic             last_row, last_col, in_window;

  assign rows_last = cfg_rows - ROW_W'(1);
  assign col_total = TOT_W'(cfg_cols) + TOT_W'(cfg_mult) + TOT_W'(cfg_ovr);
  assign col_last  = col_total - TOT_W'(1);
  assign win_lo    = TOT_W'(cfg_mult);
  assign win_hi    = TOT_W'(cfg_mult) + TOT_W'(cfg_cols);
  assign last_row  = (row_cnt == rows_last);
  assign last_col  = (col_cnt == col_last);
  assign in_window = (col_cnt >= win_lo) & (col_cnt < win_hi);

  assign par_run = (state == ST_FRAME) | (state == ST_LINE);
  assign pix_run = (state == ST_PIXEL);

  ccd_par_stepper #(.STEP_W(STEP_W)) u_par (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .run      (par_run),
    .cfg_step (cfg_step),
    .row_end  (par_row_end),
    .phase    (par_phase)
  );

  ccd_pix_timer #(
    .PIX_DIV  (PIX_DIV),
    .RST_AT   (RST_AT),
    .CLAMP_AT (CLAMP_AT),
    .SAMP_AT  (SAMP_AT)
  ) u_pix (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .run        (pix_run),
    .pix_end    (pix_end),
    .ser_ph     (ser_clk),
    .mult_clk   (mult_clk),
    .rst_gate   (rst_gate),
    .clamp_strb (clamp_strb),
    .samp_strb  (samp_strb)
  );

  // Next-state logic
  always_comb begin
    state_nx = state;
    row_nx   = row_cnt;
    col_nx   = col_cnt;
    pend_nx  = pend;
    done_nx  = 1'b0;
    if (start && state != ST_IDLE) pend_nx = 1'b1;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          state_nx = ST_FRAME;
          row_nx   = '0;
        end
      end
      ST_FRAME: begin
        if (par_row_end) begin
          if (last_row) begin
            state_nx = ST_LINE;
            row_nx   = '0;
          end else begin
            row_nx = row_cnt + ROW_W'(1);
          end
        end
      end
      ST_LINE: begin
        if (par_row_end) begin
          state_nx = ST_PIXEL;
          col_nx   = '0;
        end
      end
      ST_PIXEL: begin
        if (pix_end) begin
          if (last_col) begin
            col_nx = '0;
            if (last_row) begin
              done_nx = 1'b1;
              row_nx  = '0;
              if (pend || start) begin
                state_nx = ST_FRAME;
                pend_nx  = 1'b0;
              end else begin
                state_nx = ST_IDLE;
              end
            end else begin
              row_nx   = row_cnt + ROW_W'(1);
              state_nx = ST_LINE;
            end
          end else begin
            col_nx = col_cnt + TOT_W'(1);
          end
        end
      end
      default: state_nx = ST_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state      <= ST_IDLE;
      row_cnt    <= '0;
      col_cnt    <= '0;
      pend       <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      state      <= state_nx;
      row_cnt    <= row_nx;
      col_cnt    <= col_nx;
      pend       <= pend_nx;
      frame_done <= done_nx;
    end
  end

  assign img_clk   = (state == ST_FRAME) ? par_phase : PAR_REST;
  assign sto_clk   = par_phase;
  assign pix_valid = samp_strb & in_window;

endmodule

// File: rtl/ccd_seq_chk.sv
module ccd_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] img_clk,
  input logic [2:0] sto_clk,
  input logic [2:0] ser_clk,
  input logic       mult_clk,
  input logic       rst_gate,
  input logic       clamp_strb,
  input logic       samp_strb,
  input logic       pix_valid,
  input logic       frame_done
);

  a_r2_par_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(img_clk) == 1) && ($countones(sto_clk) == 1));

  a_r4_ser_onehot0: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ser_clk) <= 1);

  a_r5_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rst_gate, clamp_strb, samp_strb}));

  a_r6_mult_in_pixel: assert property (@(posedge clk) disable iff (!rst_n)
    mult_clk |-> (ser_clk != 3'b000));

  a_r7_valid_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> samp_strb);

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  a_r10_par_rest_serial: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk != 3'b000) |-> (img_clk == 3'b001 && sto_clk == 3'b001));

endmodule

bind ccd_seq_top ccd_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .img_clk    (img_clk),
  .sto_clk    (sto_clk),
  .ser_clk    (ser_clk),
  .mult_clk   (mult_clk),
  .rst_gate   (rst_gate),
  .clamp_strb (clamp_strb),
  .samp_strb  (samp_strb),
  .pix_valid  (pix_valid),
  .frame_done (frame_done)
);

// File: tb/tb_ccd_seq_top.sv
module tb_ccd_seq_top;
  localparam int DIV = 8;

  logic       clk = 1'b0;
  logic       rst_n, start;
  logic [9:0] cfg_rows, cfg_cols, cfg_mult;
  logic [5:0] cfg_ovr;
  logic [7:0] cfg_step;
  logic [2:0] img_clk, sto_clk, ser_clk;
  logic       mult_clk, rst_gate, clamp_strb, samp_strb, pix_valid, frame_done;

  int  vecs = 0;
  int  errs = 0;
  bit  finished = 1'b0;

  always #4 clk = ~clk;

  ccd_seq_top dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_rows(cfg_rows), .cfg_cols(cfg_cols), .cfg_mult(cfg_mult),
    .cfg_ovr(cfg_ovr), .cfg_step(cfg_step),
    .img_clk(img_clk), .sto_clk(sto_clk), .ser_clk(ser_clk),
    .mult_clk(mult_clk), .rst_gate(rst_gate), .clamp_strb(clamp_strb),
    .samp_strb(samp_strb), .pix_valid(pix_valid), .frame_done(frame_done)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic idle_expect(input string tag, input int done_exp);
    chk(tag, "img_clk", img_clk, 1);
    chk(tag, "sto_clk", sto_clk, 1);
    chk(tag, "ser_clk", ser_clk, 0);
    chk(tag, "mult_clk", mult_clk, 0);
    chk(tag, "strobes", {rst_gate, clamp_strb, samp_strb}, 0);
    chk(tag, "pix_valid", pix_valid, 0);
    chk(tag, "frame_done", frame_done, done_exp);
  endtask

  // Expected levels at edge index n of a frame, from the requirement text
  task automatic expect_cycle(input int n, input int done_exp);
    int s, tot, ftl, rowlen, m, q, u, k, p, sp;
    s      = (cfg_step == 0) ? 1 : int'(cfg_step);   // R11
    tot    = int'(cfg_cols) + int'(cfg_mult) + int'(cfg_ovr);
    ftl    = int'(cfg_rows) * 3 * s;
    rowlen = 3 * s + tot * DIV;
    chk("R8", "frame_done", frame_done, done_exp);
    if (n < ftl) begin
      chk("R2", "img_clk", img_clk, 1 << ((n / s) % 3));
      chk("R2", "sto_clk", sto_clk, 1 << ((n / s) % 3));
      chk("R2", "ser_clk", ser_clk, 0);
      chk("R2", "strobes", {mult_clk, rst_gate, clamp_strb, samp_strb}, 0);
    end else begin
      m = n - ftl;
      q = m % rowlen;
      if (q < 3 * s) begin
        chk("R3", "img_clk", img_clk, 1);
        chk("R3", "sto_clk", sto_clk, 1 << (q / s));
        chk("R3", "ser_clk", ser_clk, 0);
        chk("R3", "strobes", {mult_clk, rst_gate, clamp_strb, samp_strb}, 0);
      end else begin
        u  = q - 3 * s;
        k  = u / DIV;
        p  = u % DIV;
        sp = (p < DIV / 3) ? 0 : (p < 2 * (DIV / 3)) ? 1 : 2;
        chk("R10", "img_clk", img_clk, 1);
        chk("R10", "sto_clk", sto_clk, 1);
        chk("R4", "ser_clk", ser_clk, 1 << sp);
        chk("R6", "mult_clk", mult_clk, (p >= DIV / 2) ? 1 : 0);
        chk("R5", "rst_gate", rst_gate, (p == 0) ? 1 : 0);
        chk("R5", "clamp_strb", clamp_strb, (p == 2) ? 1 : 0);
        chk("R5", "samp_strb", samp_strb, (p == 5) ? 1 : 0);
        chk("R7", "pix_valid", pix_valid,
            (p == 5 && k >= int'(cfg_mult) && k < int'(cfg_mult) + int'(cfg_cols)) ? 1 : 0);
      end
    end
  endtask

  function automatic int frame_len();
    int s;
    s = (cfg_step == 0) ? 1 : int'(cfg_step);
    return int'(cfg_rows) * (6 * s +
           (int'(cfg_cols) + int'(cfg_mult) + int'(cfg_ovr)) * DIV);
  endfunction

  task automatic set_cfg(input int r, input int c, input int mu, input int o, input int st);
    cfg_rows = 10'(r); cfg_cols = 10'(c); cfg_mult = 10'(mu);
    cfg_ovr  = 6'(o);  cfg_step = 8'(st);
  endtask

  // Runs nfr back-to-back frames; extra starts are injected during frame 0
  task automatic run_frames(input int nfr, input bit inject);
    int fl;
    fl = frame_len();
    @(negedge clk) start = 1'b1;
    @(posedge clk);
    for (int f = 0; f < nfr; f++) begin
      for (int n = 0; n < fl; n++) begin
        @(negedge clk);
        start = inject && (f == 0) && (n == 5 || n == 30);
        expect_cycle(n, (n == 0 && f > 0) ? 1 : 0);
        @(posedge clk);
      end
    end
    @(negedge clk);
    start = 1'b0;
    idle_expect("R8", 1);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      idle_expect("R9", 0);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    start = 1'b0;
    set_cfg(3, 4, 2, 1, 2);
    repeat (3) @(negedge clk);
    idle_expect("R1", 0);
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      idle_expect("R1", 0);
    end
  endtask

  task automatic t_frame_basic;
    set_cfg(3, 4, 2, 1, 2);   // 204-cycle frame
    run_frames(1, 1'b0);
  endtask

  task automatic t_frame_step0;
    set_cfg(2, 3, 4, 0, 0);   // R11: step of 0 acts as 1
    run_frames(1, 1'b0);
  endtask

  task automatic t_pending;
    set_cfg(2, 2, 1, 2, 1);
    run_frames(2, 1'b1);      // R9: two pulses, one extra frame
  endtask

  task automatic t_reset_midframe;
    set_cfg(3, 4, 2, 1, 2);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (40) @(negedge clk);
    rst_n = 1'b0;
    #1;
    idle_expect("R1", 0);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    idle_expect("R1", 0);
    run_frames(1, 1'b0);
  endtask

  initial begin
    t_reset();
    t_frame_basic();
    t_frame_step0();
    t_pending();
    t_reset_midframe();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      vecs++;
      errs++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

endmodule